// File: doc/BRIEF.md
# Bunch-Aligned Multiplicity Summer

This block merges hit-count words from up to eight front-end channels into one total per bunch crossing. Each word carries a small count and the identifier of the crossing it belongs to. Words for the same crossing may reach the channels in any order. Each channel keeps a slot memory indexed by crossing identifier. Each slot has an occupancy flag.

Pending words are served one per clock by a round-robin arbiter. A served word is written into its slot. When the slot is then occupied in every enabled channel, the counts are added. The total leaves on a valid/ready output together with the crossing identifier. The slot is then freed in all channels.

If a word lands on a slot that is still occupied in its own channel, the earlier crossing is taken as lost. An error pulse is raised and a saturating error counter advances. Slot reuse after a full turn of the identifier space therefore acts as the timeout. A runtime input selects how many channels take part, counted upward from channel 0.

Top module: `mult_sum_builder`

## Requirements
- R1: Channel i's input word sits at `in_data_i[15*i +: 15]`. Bits [6:0] hold the count and bits [14:7] hold the crossing identifier.
- R2: Once every enabled channel has delivered a word for a crossing, in any order, `out_valid_o` rises. `out_sum_o` carries the 10-bit sum of those counts and `out_bx_o` carries the identifier. This happens on the clock edge that serves the completing word.
- R3: Only channels 0 to `n_active_i`-1 take part. A disabled channel keeps `in_ready_o` high and its words are dropped. They have no effect on any total or error.
- R4: After a crossing is emitted, its slot is free in all channels. A later word with the same identifier starts a new accumulation and raises no error.
- R5: When a channel delivers a word for a slot it already holds unconsumed, `err_o` pulses for one cycle. `err_ch_o` gives the channel and `err_bx_o` gives the identifier. The new count replaces the old one.
- R6: `err_count_o` counts collisions and saturates at all ones. Its width is ERR_W, 16 by default.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output holds its value. No pending word is served during that time.
- R8: Each channel holds one pending word and drives `in_ready_o` low while it holds it. At most one word is served per clock, in round-robin order over the channels.
- R9: Reset and a one-cycle `clr_all_i` free every slot. Counts delivered before the clear never contribute to a later total.
- R10: Several crossings may be in progress at once. Each one completes independently with its own sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_all_i | input | 1 | Free all slots in all channels |
| n_active_i | input | 4 | Number of enabled channels, counted from 0 |
| in_valid_i | input | 8 | Per-channel word valid |
| in_data_i | input | 120 | Per-channel 15-bit words, packed |
| in_ready_o | output | 8 | Per-channel ready |
| out_valid_o | output | 1 | Total valid |
| out_ready_i | input | 1 | Downstream ready |
| out_sum_o | output | 10 | Sum of counts for the crossing |
| out_bx_o | output | 8 | Crossing identifier of the total |
| err_o | output | 1 | One-cycle collision pulse |
| err_ch_o | output | 3 | Channel that collided |
| err_bx_o | output | 8 | Slot that collided |
| err_count_o | output | 16 | Saturating collision count |

## Verification
The bench delivers the words of one crossing in scrambled channel order and checks that no total appears before the last word. A design that checked only the arriving channel, or the wrong channel range, would emit early or include a disabled channel's count.

It then interleaves two crossings in one burst so that they complete on consecutive cycles. A design that mixed up slot addressing would merge them or emit the wrong identifier.

It reuses a slot after a completed crossing, after a collision and after a clear. A design that failed to free the slot would flag a false error. A design that failed to overwrite would report a stale sum.

It also stalls the output while words wait, which exposes a design that serves input and drops a finished total.

// File: rtl/mult_sum_pkg.sv
package mult_sum_pkg;
  localparam int CNT_W  = 7;
  localparam int BX_W   = 8;
  localparam int WORD_W = CNT_W + BX_W;
  localparam int DEPTH  = 1 << BX_W;

  typedef struct packed {
    logic [BX_W-1:0]  bx;
    logic [CNT_W-1:0] cnt;
  } word_t;
endpackage

// File: rtl/mult_rr_arb.sv
module mult_rr_arb #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr <= '0;
    else if (|req_i) ptr <= (idx_o == IW'(N-1)) ? '0 : idx_o + 1'b1;
  end

  assert_gnt_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0) && ((|req_i) == (|gnt_o)));
endmodule

// File: rtl/mult_slot_bank.sv
module mult_slot_bank
  import mult_sum_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             wr_en_i,
  input  logic             clr_slot_i,
  input  logic [BX_W-1:0]  addr_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[addr_i] <= wr_cnt_i;
  end

  // slot release wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags <= '0;
    else if (clr_all_i)  flags <= '0;
    else if (clr_slot_i) flags[addr_i] <= 1'b0;
    else if (wr_en_i)    flags[addr_i] <= 1'b1;
  end

  assign flag_o = flags[addr_i];
  assign cnt_o  = mem[addr_i];

  assert_clear_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (flags == '0));
endmodule

// File: rtl/mult_sum_tree.sv
module mult_sum_tree #(
  parameter int N     = 8,
  parameter int IN_W  = 7,
  parameter int OUT_W = 10
) (
  input  logic [N*IN_W-1:0] vals_i,
  input  logic [N-1:0]      mask_i,
  output logic [OUT_W-1:0]  sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++)
      if (mask_i[i]) sum_o = sum_o + OUT_W'(vals_i[i*IN_W +: IN_W]);
  end
endmodule

// File: rtl/mult_sum_builder.sv
module mult_sum_builder
  import mult_sum_pkg::*;
#(
  parameter  int N_CH  = 8,
  parameter  int ERR_W = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int NA_W  = $clog2(N_CH + 1),
  localparam int SUM_W = CNT_W + $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_all_i,
  input  logic [NA_W-1:0]        n_active_i,
  input  logic [N_CH-1:0]        in_valid_i,
  input  logic [N_CH*WORD_W-1:0] in_data_i,
  output logic [N_CH-1:0]        in_ready_o,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [SUM_W-1:0]       out_sum_o,
  output logic [BX_W-1:0]        out_bx_o,
  output logic                   err_o,
  output logic [CH_W-1:0]        err_ch_o,
  output logic [BX_W-1:0]        err_bx_o,
  output logic [ERR_W-1:0]       err_count_o
);
  logic [N_CH-1:0]       en, pend_v, req, gnt, flag_rd;
  word_t                 pend_w [N_CH];
  logic [CH_W-1:0]       gnt_idx;
  logic [N_CH*CNT_W-1:0] cnt_rd, vals;
  logic [SUM_W-1:0]      sum;
  word_t                 sel_w;
  logic                  svc_en, fire, done, collide;

  assign svc_en = !out_valid_o || out_ready_i;
  assign req    = pend_v & en & {N_CH{svc_en}};
  assign fire   = |req;
  assign sel_w  = pend_w[gnt_idx];

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    assign en[gi]         = NA_W'(gi) < n_active_i;
    assign in_ready_o[gi] = !en[gi] || !pend_v[gi];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_v[gi] <= 1'b0;
        pend_w[gi] <= '0;
      end else if (!en[gi]) begin
        pend_v[gi] <= 1'b0;
      end else if (in_valid_i[gi] && !pend_v[gi]) begin
        pend_v[gi] <= 1'b1;
        pend_w[gi] <= in_data_i[gi*WORD_W +: WORD_W];
      end else if (gnt[gi]) begin
        pend_v[gi] <= 1'b0;
      end
    end

    mult_slot_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_all_i  (clr_all_i),
      .wr_en_i    (gnt[gi]),
      .clr_slot_i (done),
      .addr_i     (sel_w.bx),
      .wr_cnt_i   (sel_w.cnt),
      .flag_o     (flag_rd[gi]),
      .cnt_o      (cnt_rd[gi*CNT_W +: CNT_W])
    );

    // the arriving count bypasses the memory read
    assign vals[gi*CNT_W +: CNT_W] = gnt[gi] ? sel_w.cnt : cnt_rd[gi*CNT_W +: CNT_W];
  end

  mult_rr_arb #(.N(N_CH)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .gnt_o  (gnt),
    .idx_o  (gnt_idx)
  );

  mult_sum_tree #(.N(N_CH), .IN_W(CNT_W), .OUT_W(SUM_W)) u_sum (
    .vals_i (vals),
    .mask_i (en),
    .sum_o  (sum)
  );

  assign done    = fire && (&(~en | flag_rd | gnt));
  assign collide = fire && (|(gnt & flag_rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sum_o   <= '0;
      out_bx_o    <= '0;
    end else if (done) begin
      out_valid_o <= 1'b1;
      out_sum_o   <= sum;
      out_bx_o    <= sel_w.bx;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      err_ch_o <= '0;
      err_bx_o <= '0;
    end else begin
      err_o <= collide;
      if (collide) begin
        err_ch_o <= gnt_idx;
        err_bx_o <= sel_w.bx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         err_count_o <= '0;
    else if (collide && !(&err_count_o)) err_count_o <= err_count_o + 1'b1;
  end

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sum_o) && $stable(out_bx_o)));

  assert_err_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((err_count_o == $past(err_count_o) + 1'b1) || (&err_count_o)));
endmodule

// File: tb/mult_sum_builder_bench.sv
module mult_sum_builder_bench;
  localparam int N    = 8;
  localparam int EW   = 4;
  localparam int WDTH = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_all = 1'b0;
  logic [3:0]    n_active = 4'd4;
  logic [N-1:0]  in_valid = '0;
  logic [N*WDTH-1:0] in_data = '0;
  logic [N-1:0]  in_ready;
  logic          out_valid, out_ready = 1'b1;
  logic [9:0]    out_sum;
  logic [7:0]    out_bx, err_bx;
  logic          err;
  logic [2:0]    err_ch;
  logic [EW-1:0] err_count;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic       c_ov, c_ev;
  logic [9:0] c_sum;
  logic [7:0] c_bx, c_ebx;
  logic [2:0] c_ech;

  always #4 clk = ~clk;

  mult_sum_builder #(.N_CH(N), .ERR_W(EW)) u_mult_sum_builder (
    .clk_i(clk), .rst_ni(rst_n), .clr_all_i(clr_all), .n_active_i(n_active),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sum_o(out_sum),
    .out_bx_o(out_bx), .err_o(err), .err_ch_o(err_ch), .err_bx_o(err_bx),
    .err_count_o(err_count));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(int na);
    @(negedge clk);
    rst_n = 1'b0; n_active = 4'(na); in_valid = '0; out_ready = 1'b1; clr_all = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic capture();
    c_ov = out_valid; c_sum = out_sum; c_bx = out_bx;
    c_ev = err; c_ech = err_ch; c_ebx = err_bx;
  endtask

  // one word: accept edge, service edge, sample at the following negedge
  task automatic send(int ch, int cnt, int bx);
    @(negedge clk);
    in_valid[ch] = 1'b1;
    in_data[ch*WDTH +: WDTH] = {8'(bx), 7'(cnt)};
    @(negedge clk);
    in_valid[ch] = 1'b0;
    @(negedge clk);
    capture();
  endtask

  task automatic t_reset();
    do_reset(4);
    chk("R8 ready after reset", int'(in_ready), 255);
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R6 err_count after reset", int'(err_count), 0);
  endtask

  task automatic t_four();
    do_reset(4);
    send(2, 100, 17); send(0, 127, 17); send(3, 5, 17);
    chk("R2 no early total", int'(c_ov), 0);
    send(1, 64, 17);
    chk("R2 valid", int'(c_ov), 1);
    chk("R1 R2 sum", int'(c_sum), 296);
    chk("R2 bx", int'(c_bx), 17);
    for (int i = 3; i >= 0; i--) send(i, 127, 255);
    chk("R1 max sum", int'(c_sum), 508);
    chk("R1 max bx", int'(c_bx), 255);
  endtask

  task automatic t_seven();
    do_reset(7);
    @(negedge clk);
    chk("R3 disabled ch7 ready", int'(in_ready[7]), 1);
    send(7, 99, 3);
    chk("R3 ch7 no output", int'(c_ov), 0);
    for (int i = 6; i >= 1; i--) send(i, i*10+1, 3);
    chk("R2 seven not early", int'(c_ov), 0);
    send(0, 1, 3);
    chk("R2 seven valid", int'(c_ov), 1);
    chk("R3 seven sum", int'(c_sum), 217);
  endtask

  task automatic t_disabled();
    do_reset(4);
    send(5, 50, 9);
    chk("R3 disabled no out", int'(c_ov), 0);
    chk("R3 disabled no err", int'(c_ev), 0);
    send(5, 50, 9);
    chk("R3 disabled no collision", int'(c_ev), 0);
    for (int i = 0; i < 4; i++) send(i, 1, 9);
    chk("R3 disabled excluded", int'(c_sum), 4);
  endtask

  task automatic t_reuse();
    do_reset(4);
    for (int i = 0; i < 4; i++) send(i, i+1, 40);
    chk("R4 first sum", int'(c_sum), 10);
    send(0, 7, 40);
    chk("R4 reuse no err", int'(c_ev), 0);
    chk("R4 reuse no out", int'(c_ov), 0);
    for (int i = 1; i < 4; i++) send(i, 1, 40);
    chk("R4 second sum", int'(c_sum), 10);
    chk("R4 err_count", int'(err_count), 0);
  endtask

  task automatic t_collide();
    do_reset(4);
    send(1, 3, 5);
    send(1, 9, 5);
    chk("R5 err pulse", int'(c_ev), 1);
    chk("R5 err ch", int'(c_ech), 1);
    chk("R5 err bx", int'(c_ebx), 5);
    chk("R5 no out", int'(c_ov), 0);
    @(negedge clk);
    chk("R5 one cycle", int'(err), 0);
    chk("R6 count one", int'(err_count), 1);
    send(0, 1, 5); send(2, 2, 5); send(3, 4, 5);
    chk("R5 overwrite sum", int'(c_sum), 16);
  endtask

  task automatic t_saturate();
    do_reset(4);
    send(0, 1, 7);
    for (int i = 0; i < 20; i++) send(0, 1, 7);
    chk("R6 saturated", int'(err_count), 15);
  endtask

  task automatic t_stall();
    do_reset(4);
    out_ready = 1'b0;
    send(0, 10, 60); send(1, 20, 60); send(2, 30, 60); send(3, 40, 60);
    chk("R7 stalled valid", int'(c_ov), 1);
    @(negedge clk);
    in_valid[0] = 1'b1; in_data[0 +: WDTH] = {8'd61, 7'd5};
    @(negedge clk);
    in_valid[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 hold sum", int'(out_sum), 100);
    chk("R7 hold bx", int'(out_bx), 60);
    chk("R7 R8 not served", int'(in_ready[0]), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 drained", int'(out_valid), 0);
    chk("R8 served after stall", int'(in_ready[0]), 1);
    send(1, 6, 61); send(2, 7, 61); send(3, 8, 61);
    chk("R7 after stall sum", int'(c_sum), 26);
  endtask

  task automatic t_interleave();
    do_reset(4);
    @(negedge clk);
    in_valid[3:0] = 4'hf;
    in_data[0*WDTH +: WDTH] = {8'd30, 7'd1};
    in_data[1*WDTH +: WDTH] = {8'd31, 7'd2};
    in_data[2*WDTH +: WDTH] = {8'd30, 7'd3};
    in_data[3*WDTH +: WDTH] = {8'd31, 7'd4};
    @(negedge clk);
    in_valid = '0;
    chk("R8 all pending", int'(in_ready[3:0]), 0);
    repeat (4) @(negedge clk);
    chk("R10 none complete", int'(out_valid), 0);
    in_valid[3:0] = 4'hf;
    in_data[0*WDTH +: WDTH] = {8'd31, 7'd5};
    in_data[1*WDTH +: WDTH] = {8'd30, 7'd6};
    in_data[2*WDTH +: WDTH] = {8'd31, 7'd7};
    in_data[3*WDTH +: WDTH] = {8'd30, 7'd9};
    @(negedge clk);
    in_valid = '0;
    repeat (2) @(negedge clk);
    chk("R8 R10 not before third", int'(out_valid), 0);
    @(negedge clk);
    chk("R10 first valid", int'(out_valid), 1);
    chk("R10 first bx", int'(out_bx), 31);
    chk("R10 first sum", int'(out_sum), 18);
    @(negedge clk);
    chk("R10 second bx", int'(out_bx), 30);
    chk("R10 second sum", int'(out_sum), 19);
  endtask

  task automatic t_clear();
    do_reset(4);
    send(0, 5, 20); send(1, 6, 20);
    @(negedge clk); clr_all = 1'b1;
    @(negedge clk); clr_all = 1'b0;
    send(2, 7, 20); send(3, 8, 20);
    chk("R9 no out after clear", int'(c_ov), 0);
    chk("R9 no err after clear", int'(c_ev), 0);
    send(0, 1, 20); send(1, 2, 20);
    chk("R9 fresh total", int'(c_sum), 18);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_four();
    t_seven();
    t_disabled();
    t_reuse();
    t_collide();
    t_saturate();
    t_stall();
    t_interleave();
    t_clear();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule